// File: doc/BRIEF.md
# Event-Armed Sync Counter Queue

This block lets software arm hardware events so that a counter advances when an armed event fires. Software writes a request word over a simple register bus with a valid/ready handshake. Each request carries a condition code, which names one event input, and a counter index. The request waits in a small queue that belongs to that condition. When the event pulse arrives, the block removes the oldest waiting request for that condition and increments the named counter by one.

There are six capture ports. Each port has two event inputs: one for the start of a frame and one for the end of a memory write. That gives twelve queues, each two entries deep. If software writes a request to a full queue, the block either holds the bus until an entry frees up, or it drops the request and sets an error bit for that condition. A control bit chooses between the two. The same bus reads back the counters, the control register and the error register. A separate software-increment input can bump any counter directly.

Top module: `sevq_top`

## Requirements
- R1: A write to address 0 is a request. Bits 15:8 carry the condition code and bits 7:0 carry the counter index. For port p, the frame-start event `ev_frame_start[p]` uses code 5+4p, and the write-done event `ev_wr_ack[p]` uses code 7+4p.
- R2: If a queue holds at least one entry when its event is high on a clock edge, the oldest entry is removed at that edge and its counter increases by exactly one. A read of address 8+i that is accepted at one edge presents counter i on `bus_rdata` after that edge.
- R3: Each condition queue holds two entries and releases them in the order they were written.
- R4: Bit 8 of the control register (address 1) is the drop-on-full bit. When it is clear, a request to a full queue keeps `bus_ready` low until an event frees an entry. The write is then accepted.
- R5: When bit 8 of the control register is set, a request to a full queue is accepted at once and discarded. The bit of the error register (address 2) whose position equals the condition code is set.
- R6: The error register is cleared by writing ones. Writing one to a bit clears only that bit, and all other bits keep their value. If a clear and a new drop hit the same bit in the same cycle, the bit stays set.
- R7: An event that arrives while its queue is empty is ignored, and no counter changes.
- R8: Counters are 32 bits wide and wrap modulo 2^32. The read value is the full counter.
- R9: A software increment and a queue pop that target the same counter in the same cycle are both applied, giving +2. A software increment on its own gives +1.
- R10: A request whose condition code is not mapped, or whose counter index is 6 or higher, is accepted without a stall. It is then discarded, and no queue, counter or error bit changes.
- R11: After reset, all queues are empty and all counters, the control register and the error register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted on this edge when high |
| bus_rdata | output | 32 | Read data, registered on read acceptance |
| ev_frame_start | input | 6 | Frame-start event pulse per port |
| ev_wr_ack | input | 6 | Memory-write-done event pulse per port |
| sw_incr | input | 1 | Software increment strobe |
| sw_incr_idx | input | 3 | Counter targeted by the software increment |

## Verification
On every cycle, the assertions check four things. A push never lands in a full queue, and a pop never comes from an empty one. The bus stalls only on a write while the drop-on-full bit is clear. An error bit rises only after a dropped request, and counters stay still when nothing targets them. The bench scenarios cover the behaviour that depends on history:
- queue order across two pops,
- the exact counter values after stalls and drops,
- the +2 result when a pop and a software increment coincide,
- masked clearing of the error register,
- silent rejection of malformed requests.

// File: rtl/sevq_pkg.sv
package sevq_pkg;
  localparam int BUS_W      = 32;
  localparam int COND_W     = 8;
  localparam int ADDR_REQ   = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_ERR   = 2;
  localparam int ADDR_CNT0  = 8;
  localparam int NOSTALL_BIT = 8;

  typedef struct packed {
    logic       hit;
    logic [7:0] q;
  } qsel_t;

  // condition code -> queue number (2*port + kind), kind 0 frame start, 1 write done
  function automatic qsel_t cond_to_queue(input logic [COND_W-1:0] code, input int nports);
    qsel_t r;
    int    rel;
    r = '0;
    if (int'(code) >= 5) begin
      rel = int'(code) - 5;
      if ((rel % 2) == 0 && (rel / 4) < nports) begin
        r.hit = 1'b1;
        r.q   = 8'(2 * (rel / 4) + ((rel / 2) % 2));
      end
    end
    return r;
  endfunction

  // queue number -> condition code
  function automatic logic [COND_W-1:0] queue_to_cond(input int q);
    return COND_W'(5 + 4 * (q / 2) + 2 * (q % 2));
  endfunction
endpackage

// File: rtl/sevq_fifo.sv
module sevq_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sevq_counter_bank.sv
module sevq_counter_bank #(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32,
  parameter int NQ      = 12,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NQ-1:0]            q_pop,
  input  logic [NQ*IDX_W-1:0]      q_head,
  input  logic                     sw_incr,
  input  logic [IDX_W-1:0]         sw_incr_idx,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  localparam int HW = $clog2(NQ + 2) + 1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                            input logic [HW-1:0] hw,
                                            input logic sw);
    return cur + CNT_W'(hw) + CNT_W'(sw);
  endfunction

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [HW-1:0]    hits;
    logic             sw_hit;
    logic [CNT_W-1:0] value;

    always_comb begin
      hits = '0;
      for (int q = 0; q < NQ; q++) begin
        if (q_pop[q] && (q_head[q*IDX_W +: IDX_W] == IDX_W'(i))) hits = hits + HW'(1);
      end
    end

    assign sw_hit = sw_incr && (sw_incr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= bump(value, hits, sw_hit);
    end

    assign cnt_flat[i*CNT_W +: CNT_W] = value;
  end
endmodule

// File: rtl/sevq_top.sv
module sevq_top
  import sevq_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int FIFO_DEPTH = 2,
  parameter int NUM_CNT    = 6,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 5,
  localparam int IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic                 bus_ready,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [NUM_PORTS-1:0] ev_frame_start,
  input  logic [NUM_PORTS-1:0] ev_wr_ack,
  input  logic                 sw_incr,
  input  logic [IDX_W-1:0]     sw_incr_idx
);
  localparam int NQ = 2 * NUM_PORTS;

  // named internal events for the checker
  logic [NQ-1:0]            q_push, q_pop, q_full, q_empty, q_event;
  logic [NQ*IDX_W-1:0]      q_head;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     ctrl_nostall;
  logic [BUS_W-1:0]         err_q;
  logic                     wr_req, legal_req, tgt_full, stall_evt, push_evt, drop_evt;
  qsel_t                    sel;
  logic [COND_W-1:0]        req_cond;
  logic [7:0]               req_idx;
  logic                     idx_ok;

  assign req_cond  = bus_wdata[15:8];
  assign req_idx   = bus_wdata[7:0];
  assign sel       = cond_to_queue(req_cond, NUM_PORTS);
  assign idx_ok    = (int'(req_idx) < NUM_CNT);
  assign wr_req    = bus_valid && bus_write && (int'(bus_addr) == ADDR_REQ);
  assign legal_req = wr_req && sel.hit && idx_ok;
  assign tgt_full  = sel.hit ? q_full[int'(sel.q) % NQ] : 1'b0;
  assign stall_evt = legal_req && tgt_full && !ctrl_nostall;
  assign push_evt  = legal_req && !tgt_full;
  assign drop_evt  = legal_req && tgt_full && ctrl_nostall;
  assign bus_ready = !stall_evt;

  // event vector: even queue = frame start, odd = write done
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ev
    assign q_event[2*p]     = ev_frame_start[p];
    assign q_event[2*p + 1] = ev_wr_ack[p];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_push[q] = push_evt && (int'(sel.q) == q);
    assign q_pop[q]  = q_event[q] && !q_empty[q];
    sevq_fifo #(.DEPTH(FIFO_DEPTH), .W(IDX_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[q]),
      .din   (req_idx[IDX_W-1:0]),
      .pop   (q_pop[q]),
      .dout  (q_head[q*IDX_W +: IDX_W]),
      .full  (q_full[q]),
      .empty (q_empty[q])
    );
  end

  sevq_counter_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NQ(NQ), .IDX_W(IDX_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_pop       (q_pop),
    .q_head      (q_head),
    .sw_incr     (sw_incr),
    .sw_incr_idx (sw_incr_idx),
    .cnt_flat    (cnt_flat)
  );

  // control and error registers
  logic             wr_ctrl, wr_err;
  logic [BUS_W-1:0] err_set;
  assign wr_ctrl = bus_valid && bus_write && (int'(bus_addr) == ADDR_CTRL);
  assign wr_err  = bus_valid && bus_write && (int'(bus_addr) == ADDR_ERR);
  assign err_set = drop_evt ? (BUS_W'(1) << req_cond) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_nostall <= 1'b0;
      err_q        <= '0;
    end else begin
      if (wr_ctrl) ctrl_nostall <= bus_wdata[NOSTALL_BIT];
      err_q <= (wr_err ? (err_q & ~bus_wdata) : err_q) | err_set;
    end
  end

  // read path
  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) == ADDR_CTRL) rd_mux[NOSTALL_BIT] = ctrl_nostall;
    else if (int'(bus_addr) == ADDR_ERR) rd_mux = err_q;
    else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (int'(bus_addr) == ADDR_CNT0 + i) rd_mux = BUS_W'(cnt_flat[i*CNT_W +: CNT_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sevq_checker.sv
module sevq_checker #(
  parameter int NQ      = 12,
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic                     bus_ready,
  input logic                     ctrl_nostall,
  input logic [NQ-1:0]            q_push,
  input logic [NQ-1:0]            q_pop,
  input logic [NQ-1:0]            q_full,
  input logic [NQ-1:0]            q_empty,
  input logic                     drop_evt,
  input logic                     sw_incr,
  input logic [31:0]              err_q,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |-> (bus_write && !ctrl_nostall));

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push & q_full) == '0);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full & q_empty) == '0);

  assert_empty_event_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & q_empty) == '0);

  assert_err_rise_from_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & ~$past(err_q)) != '0) |-> $past(drop_evt));

  assert_counters_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop == '0 && !sw_incr) |=> $stable(cnt_flat));

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |=> (err_q == '0 && cnt_flat == '0 && !ctrl_nostall));
endmodule

bind sevq_top sevq_checker #(.NQ(NQ), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_ready    (bus_ready),
  .ctrl_nostall (ctrl_nostall),
  .q_push       (q_push),
  .q_pop        (q_pop),
  .q_full       (q_full),
  .q_empty      (q_empty),
  .drop_evt     (drop_evt),
  .sw_incr      (sw_incr),
  .err_q        (err_q),
  .cnt_flat     (cnt_flat)
);

// File: tb/tb_sevq_top.sv
module tb_sevq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [5:0]  ev_frame_start = '0, ev_wr_ack = '0;
  logic        sw_incr = 1'b0;
  logic [2:0]  sw_incr_idx = '0;

  int tests = 0, fails = 0, cyc = 0;
  int unsigned exp_cnt [6];
  logic [31:0] rd;

  always #5 clk = ~clk;

  sevq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .ev_frame_start(ev_frame_start), .ev_wr_ack(ev_wr_ack),
    .sw_incr(sw_incr), .sw_incr_idx(sw_incr_idx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // table: {port, kind, counter}; kind 0 = frame start, 1 = write done
  localparam logic [11:0] VEC [8] = '{
    12'h000, 12'h011, 12'h102, 12'h213, 12'h304, 12'h415, 12'h500, 12'h515};

  function automatic logic [7:0] code_of(input int p, input int k);
    return 8'(5 + 4 * p + (k ? 2 : 0));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    int guard = 0;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    #1;
    while (!bus_ready && guard < 50) begin @(negedge clk); #1; guard++; end
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'(a);
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_valid = 1'b0;
  endtask

  task automatic pulse(input int p, input int k);
    if (k == 0) ev_frame_start[p] = 1'b1; else ev_wr_ack[p] = 1'b1;
    @(negedge clk);
    ev_frame_start = '0; ev_wr_ack = '0;
  endtask

  task automatic chk_cnt(input string req, input int i);
    bus_rd(8 + i, rd);
    chk(req, rd, exp_cnt[i]);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    bus_rd(1, rd); chk("R11 ctrl", rd, 32'h0);
    bus_rd(2, rd); chk("R11 err", rd, 32'h0);
    for (int i = 0; i < 6; i++) chk_cnt("R11 counter", i);

    // R1 R2 R8: table walk
    for (int v = 0; v < 8; v++) begin
      int p = int'(VEC[v][11:8]);
      int k = int'(VEC[v][7:4]);
      int c = int'(VEC[v][3:0]);
      bus_wr(0, {16'h0, code_of(p, k), 8'(c)});
      pulse(p, k);
      exp_cnt[c]++;
      chk_cnt("R1 R2 R8 table", c);
    end

    // R3 ordering
    bus_wr(0, {16'h0, code_of(0, 1), 8'd1});
    bus_wr(0, {16'h0, code_of(0, 1), 8'd2});
    pulse(0, 1); exp_cnt[1]++;
    chk_cnt("R3 first pop", 1);
    chk_cnt("R3 second untouched", 2);
    pulse(0, 1); exp_cnt[2]++;
    chk_cnt("R3 second pop", 2);

    // R7 event on empty queue
    pulse(3, 0); pulse(2, 1);
    for (int i = 0; i < 6; i++) chk_cnt("R7 empty event", i);

    // R4 stall
    bus_wr(0, {16'h0, code_of(0, 0), 8'd0});
    bus_wr(0, {16'h0, code_of(0, 0), 8'd0});
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'd0; bus_wdata = {16'h0, code_of(0, 0), 8'd0};
    #1; chk("R4 ready low when full", 32'(bus_ready), 32'h0);
    @(negedge clk); #1; chk("R4 still held", 32'(bus_ready), 32'h0);
    ev_frame_start[0] = 1'b1;
    @(negedge clk); ev_frame_start = '0; exp_cnt[0]++;
    #1; chk("R4 ready after pop", 32'(bus_ready), 32'h1);
    @(posedge clk); @(negedge clk); bus_valid = 1'b0; bus_write = 1'b0;
    pulse(0, 0); pulse(0, 0); exp_cnt[0] += 2;
    chk_cnt("R4 all three counted", 0);

    // R9 coincident software and hardware increment
    bus_wr(0, {16'h0, code_of(1, 1), 8'd3});
    ev_wr_ack[1] = 1'b1; sw_incr = 1'b1; sw_incr_idx = 3'd3;
    @(negedge clk); ev_wr_ack = '0; sw_incr = 1'b0; exp_cnt[3] += 2;
    chk_cnt("R9 plus two", 3);
    sw_incr = 1'b1; sw_incr_idx = 3'd4;
    @(negedge clk); sw_incr = 1'b0; exp_cnt[4]++;
    chk_cnt("R9 software only", 4);

    // R5 drop mode
    bus_wr(1, 32'h100);
    bus_rd(1, rd); chk("R5 ctrl readback", rd, 32'h100);
    for (int n = 0; n < 3; n++) bus_wr(0, {16'h0, code_of(1, 0), 8'd0});
    bus_rd(2, rd); chk("R5 err bit 9", rd, 32'h200);
    pulse(1, 0); pulse(1, 0); pulse(1, 0); exp_cnt[0] += 2;
    chk_cnt("R5 only two kept", 0);

    // R6 write-one-to-clear
    bus_wr(2, 32'h20);
    bus_rd(2, rd); chk("R6 other bit kept", rd, 32'h200);
    bus_wr(2, 32'h200);
    bus_rd(2, rd); chk("R6 bit cleared", rd, 32'h0);

    // R10 malformed requests
    for (int n = 0; n < 3; n++) bus_wr(0, {16'h0, 8'd6, 8'd0});
    bus_wr(0, {16'h0, 8'd31, 8'd0});
    for (int n = 0; n < 3; n++) bus_wr(0, {16'h0, code_of(0, 0), 8'd6});
    bus_rd(2, rd); chk("R10 no error bit", rd, 32'h0);
    pulse(0, 0);
    for (int i = 0; i < 6; i++) chk_cnt("R10 counters unchanged", i);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule